// File: doc/BRIEF.md
# Command descriptor fetch engine

For one storage channel, this block loads a single 16-byte command descriptor out of system memory and decodes it. A slot selector elsewhere picks one of the command list entries and pulses start. The block then computes the descriptor address and issues four 32-bit reads, one at a time, through a simple word-wide read master. The descriptor address is the 64-bit list base plus sixteen times the slot index.

Once the fourth word has returned, the block raises a one-cycle done strobe and presents the decoded fields. These are the write-direction flag, the data buffer count, the transferred byte count and the 64-bit command table address. If any read returns an error response, the fetch stops at once and a one-cycle error strobe is raised instead of done.

Top module: `cmd_desc_fetch`

## Requirements
- R1: After reset the block is idle: busy, rd_req, done and err are low, and all decoded fields read zero.
- R2: A start pulse while idle raises rd_req in the next cycle. rd_addr then equals {clb_hi, clb_lo} + 16 × slot, with full 64-bit carry from the low half into the high half.
- R3: Exactly four reads are issued per fetch, to descriptor offsets 0, 4, 8 and 12 in that order. rd_req is high for one cycle per read. The next read is issued in the cycle after the previous response, and there is never more than one read outstanding.
- R4: done is high for exactly one cycle, in the cycle after the fourth error-free response. busy is high from the cycle after start until that done cycle, and low during it.
- R5: Bytes are little-endian within each word. is_write is bit 6 of word 0, buf_cnt is bits 31:16 of word 0, xfer_cnt is word 1, and ctab_addr is {word 3, word 2}. Each field changes only in the cycle after the response that carries its word is accepted.
- R6: A response with rd_rerr high aborts the fetch. err pulses for one cycle in the next cycle, done does not pulse, no further read is issued, and the block returns to idle.
- R7: A start pulse while busy is ignored, and so is a response (rd_rvalid) arriving while no read is outstanding. Neither changes the read sequence or any decoded field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a fetch (taken only while idle) |
| slot | input | 5 | Descriptor slot index |
| clb_lo | input | 32 | Command list base, low half |
| clb_hi | input | 32 | Command list base, high half |
| rd_req | output | 1 | Read request, one cycle per word |
| rd_addr | output | 64 | Byte address of the requested word |
| rd_rvalid | input | 1 | Read response valid |
| rd_rdata | input | 32 | Read response data |
| rd_rerr | input | 1 | Read response error |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | Descriptor decoded, one-cycle strobe |
| err | output | 1 | Fetch aborted by a read error, one-cycle strobe |
| is_write | output | 1 | Direction flag, 1 = write |
| buf_cnt | output | 16 | Number of data buffers |
| xfer_cnt | output | 32 | Bytes transferred |
| ctab_addr | output | 64 | Command table base address |

## Verification
Each result is due a fixed number of cycles after its stimulus: the first rd_req one cycle after start, each later rd_req one cycle after the previous response, and the decoded fields, done and err one cycle after the response that causes them. A behavioural model in the bench advances on every rising edge from the same inputs. It predicts each output for the coming cycle, and every output is compared with that prediction at the falling edge, so a result that comes a cycle early or late is caught. Scenarios vary response latency from one to three cycles. They cover slot 31 with a carry into the high half of the base, an error on the third word, a start while busy, a stray response while idle, and a new start in the done cycle.

// File: rtl/cmd_desc_fetch.sv
module cmd_desc_fetch #(
  parameter int SLOTS = 32,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SLOT_W-1:0] slot,
  input  logic [31:0]       clb_lo,
  input  logic [31:0]       clb_hi,
  output logic              rd_req,
  output logic [63:0]       rd_addr,
  input  logic              rd_rvalid,
  input  logic [31:0]       rd_rdata,
  input  logic              rd_rerr,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              is_write,
  output logic [15:0]       buf_cnt,
  output logic [31:0]       xfer_cnt,
  output logic [63:0]       ctab_addr
);
  localparam int DESC_SHIFT = 4;
  localparam int PAD_W = 64 - SLOT_W - DESC_SHIFT;
  localparam int WRITE_BIT = 6;

  typedef enum logic [1:0] {IDLE, ISSUE, WAIT} st_t;
  st_t        st;
  logic [1:0] idx;
  logic [63:0] base_q;
  logic       take;

  assign rd_req  = (st == ISSUE);
  assign busy    = (st != IDLE);
  assign rd_addr = base_q + {60'd0, idx, 2'b00};
  assign take    = (st == WAIT) && rd_rvalid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      idx    <= 2'd0;
      base_q <= 64'd0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        IDLE: if (start) begin
          base_q <= {clb_hi, clb_lo} + {{PAD_W{1'b0}}, slot, {DESC_SHIFT{1'b0}}};
          idx    <= 2'd0;
          st     <= ISSUE;
        end
        ISSUE: st <= WAIT;
        WAIT: if (rd_rvalid) begin
          if (rd_rerr) begin
            err <= 1'b1;
            st  <= IDLE;
          end else if (idx == 2'd3) begin
            done <= 1'b1;
            st   <= IDLE;
          end else begin
            idx <= idx + 2'd1;
            st  <= ISSUE;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_write  <= 1'b0;
      buf_cnt   <= 16'd0;
      xfer_cnt  <= 32'd0;
      ctab_addr <= 64'd0;
    end else if (take && !rd_rerr) begin
      case (idx)
        2'd0: begin
          is_write <= rd_rdata[WRITE_BIT];
          buf_cnt  <= rd_rdata[31:16];
        end
        2'd1: xfer_cnt <= rd_rdata;
        2'd2: ctab_addr[31:0] <= rd_rdata;
        default: ctab_addr[63:32] <= rd_rdata;
      endcase
    end
  end
endmodule

// File: rtl/cmd_desc_fetch_chk.sv
module cmd_desc_fetch_chk #(
  parameter int SLOT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [SLOT_W-1:0] slot,
  input logic [31:0]       clb_lo,
  input logic [31:0]       clb_hi,
  input logic              rd_req,
  input logic [63:0]       rd_addr,
  input logic              rd_rvalid,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              is_write,
  input logic [15:0]       buf_cnt,
  input logic [31:0]       xfer_cnt,
  input logic [63:0]       ctab_addr
);
  localparam int PAD_W = 64 - SLOT_W - 4;

  assert_req_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (rd_req && rd_addr == $past({clb_hi, clb_lo} + {{PAD_W{1'b0}}, slot, 4'b0000})));

  assert_req_single_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !rd_req));

  assert_fields_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_rvalid |=> $stable({is_write, buf_cnt, xfer_cnt, ctab_addr}));

  assert_err_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!done && !busy && !rd_req));

  assert_idle_resp_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> (!busy && $stable({is_write, buf_cnt, xfer_cnt, ctab_addr})));
endmodule

bind cmd_desc_fetch cmd_desc_fetch_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .slot(slot), .clb_lo(clb_lo), .clb_hi(clb_hi),
  .rd_req(rd_req), .rd_addr(rd_addr), .rd_rvalid(rd_rvalid), .busy(busy), .done(done),
  .err(err), .is_write(is_write), .buf_cnt(buf_cnt), .xfer_cnt(xfer_cnt), .ctab_addr(ctab_addr)
);

// File: tb/cmd_desc_fetch_bench.sv
`timescale 1ns/1ps
module cmd_desc_fetch_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0;
  logic [4:0] slot = '0;
  logic [31:0] clb_lo = '0, clb_hi = '0;
  logic rd_req, busy, done, err, is_write;
  logic [63:0] rd_addr, ctab_addr;
  logic rd_rvalid = 1'b0, rd_rerr = 1'b0;
  logic [31:0] rd_rdata = '0, xfer_cnt;
  logic [15:0] buf_cnt;

  cmd_desc_fetch u_cmd_desc_fetch (
    .clk(clk), .rst_n(rst_n), .start(start), .slot(slot), .clb_lo(clb_lo), .clb_hi(clb_hi),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata),
    .rd_rerr(rd_rerr), .busy(busy), .done(done), .err(err), .is_write(is_write),
    .buf_cnt(buf_cnt), .xfer_cnt(xfer_cnt), .ctab_addr(ctab_addr)
  );

  int tests = 0, fails = 0;
  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [63:0] a);
    return (a[31:0] * 32'h9E3779B1) ^ a[63:32] ^ {a[7:0], 24'h5A3C1};
  endfunction

  // responder
  int lat = 1;
  logic [63:0] err_addr = '1;
  bit pend = 0, spur = 0;
  int cnt = 0;
  logic [63:0] paddr = '0;
  int nreq = 0, ndone = 0, nerr = 0;

  always @(posedge clk) begin
    if (rd_req) begin
      pend  = 1;
      paddr = rd_addr;
      cnt   = lat;
      nreq++;
    end
    if (done) ndone++;
    if (err) nerr++;
  end

  always @(negedge clk) begin
    #1;
    rd_rvalid = 1'b0;
    rd_rerr   = 1'b0;
    if (spur) begin
      rd_rvalid = 1'b1;
      rd_rdata  = 32'hFFFF_FFFF;
      spur = 0;
    end else if (pend) begin
      if (cnt <= 1) begin
        rd_rvalid = 1'b1;
        rd_rdata  = mem_word(paddr);
        rd_rerr   = (paddr == err_addr);
        pend = 0;
      end else cnt--;
    end
  end

  // reference model
  int ms = 0, midx = 0;
  logic [63:0] mbase = '0;
  logic [31:0] mw [4];
  bit e_done = 0, e_err = 0;
  initial for (int i = 0; i < 4; i++) mw[i] = '0;

  always @(posedge clk) begin
    e_done = 0;
    e_err  = 0;
    if (!rst_n) begin
      ms = 0; midx = 0; mbase = '0;
      for (int i = 0; i < 4; i++) mw[i] = '0;
    end else begin
      case (ms)
        0: if (start) begin
          mbase = {clb_hi, clb_lo} + 64'(slot) * 64'd16;
          midx = 0;
          ms = 1;
        end
        1: ms = 2;
        default: if (rd_rvalid) begin
          if (rd_rerr) begin
            e_err = 1; ms = 0;
          end else begin
            mw[midx] = rd_rdata;
            if (midx == 3) begin e_done = 1; ms = 0; end
            else begin midx++; ms = 1; end
          end
        end
      endcase
    end
  end

  bit live = 0;
  always @(negedge clk) if (live) begin
    check(rd_req == (ms == 1), "R3 rd_req", 64'(rd_req), 64'(ms == 1));
    if (ms == 1) check(rd_addr == mbase + 64'(midx * 4), "R2 rd_addr", rd_addr, mbase + 64'(midx * 4));
    check(busy == (ms != 0), "R4 busy", 64'(busy), 64'(ms != 0));
    check(done == e_done, "R4 done", 64'(done), 64'(e_done));
    check(err == e_err, "R6 err", 64'(err), 64'(e_err));
    check(is_write == mw[0][6], "R5 is_write", 64'(is_write), 64'(mw[0][6]));
    check(buf_cnt == mw[0][31:16], "R5 buf_cnt", 64'(buf_cnt), 64'(mw[0][31:16]));
    check(xfer_cnt == mw[1], "R5 xfer_cnt", 64'(xfer_cnt), 64'(mw[1]));
    check(ctab_addr == {mw[3], mw[2]}, "R5 ctab_addr", ctab_addr, {mw[3], mw[2]});
  end

  task automatic pulse_start(input logic [4:0] s, input logic [63:0] b);
    @(negedge clk); #1;
    slot = s; clb_lo = b[31:0]; clb_hi = b[63:32]; start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
    repeat (2) @(negedge clk);
  endtask

  task automatic fetch(input logic [4:0] s, input logic [63:0] b, input int l);
    int r0, d0;
    lat = l;
    r0 = nreq; d0 = ndone;
    pulse_start(s, b);
    wait_idle();
    check(nreq - r0 == 4, "R3 reads per fetch", 64'(nreq - r0), 64'd4);
    check(ndone - d0 == 1, "R4 done count", 64'(ndone - d0), 64'd1);
  endtask

  initial begin
    logic [63:0] base, snap;
    int r0, d0, e0;
    repeat (3) @(negedge clk);
    check(!busy && !rd_req && !done && !err, "R1 idle flags", {busy, rd_req, done, err}, 64'd0);
    check(ctab_addr == 0 && xfer_cnt == 0 && buf_cnt == 0 && !is_write, "R1 fields", ctab_addr, 64'd0);
    #1 rst_n = 1'b1;
    live = 1;

    fetch(5'd0, 64'h0, 1);
    fetch(5'd3, 64'h0000_0010_0000_1000, 2);
    fetch(5'd31, 64'h0000_0001_FFFF_FFF0, 3);
    check(ctab_addr == {mem_word(64'h0000_0002_0000_01EC), mem_word(64'h0000_0002_0000_01E8)},
          "R2 carry address", ctab_addr, 64'd0);
    fetch(5'd17, 64'h1234_5678_9ABC_DE00, 1);

    // error on third word
    base = 64'h0000_0000_4000_0000;
    err_addr = base + 64'd5 * 64'd16 + 64'd8;
    r0 = nreq; e0 = nerr; d0 = ndone; lat = 2;
    pulse_start(5'd5, base);
    wait_idle();
    check(nreq - r0 == 3, "R6 no read after error", 64'(nreq - r0), 64'd3);
    check(nerr - e0 == 1, "R6 err count", 64'(nerr - e0), 64'd1);
    check(ndone == d0, "R6 no done", 64'(ndone - d0), 64'd0);
    err_addr = '1;

    // start while busy ignored
    r0 = nreq; d0 = ndone; lat = 3;
    pulse_start(5'd9, 64'h8000);
    pulse_start(5'd1, 64'hDEAD_0000);
    wait_idle();
    check(nreq - r0 == 4, "R7 start while busy", 64'(nreq - r0), 64'd4);
    check(ndone - d0 == 1, "R7 single done", 64'(ndone - d0), 64'd1);
    check(ctab_addr == {mem_word(64'h8000 + 144 + 12), mem_word(64'h8000 + 144 + 8)},
          "R7 fields from first slot", ctab_addr, 64'd0);

    // stray response while idle
    snap = ctab_addr;
    @(negedge clk); spur = 1;
    repeat (3) @(negedge clk);
    check(ctab_addr == snap && !busy, "R7 stray response", ctab_addr, snap);

    // start in the done cycle
    lat = 1;
    pulse_start(5'd2, 64'h100);
    do @(negedge clk); while (!done);
    #1 slot = 5'd4; start = 1'b1;
    @(negedge clk); #1 start = 1'b0;
    check(busy, "R4 restart on done cycle", 64'(busy), 64'd1);
    wait_idle();

    live = 0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule